// File: doc/BRIEF.md
# Partitioned SIMD Integer Multiplier

This block multiplies two 64-bit operands. The operands can be treated as one 64-bit lane or split into independent lanes of 8, 16 or 32 bits. A vector of seven boundary flags picks the lane layout at run time. Each lane has its own operation code. The code selects the signedness of each operand and whether the lane returns the low or the high half of its product.

Every accepted operand pair gives two results:
- a 64-bit packed result, with one lane-width field per lane;
- a 128-bit packed vector that holds every lane's full double-width product.

The block sits inside a pipeline and uses valid/ready handshakes on both sides. It has two register stages. Layout decoding happens in the first stage. The lane multipliers and the result assembly feed the second stage. A low output ready freezes both stages at once.

Top module: `simd_mul_part`

## Requirements
- R1: Lanes are packed from bit 0 upward, and each lane starts where the previous one ended. Flag bit i of `in_bounds` marks a lane boundary at bit 8*(i+1). Only naturally aligned layouts with lanes of 8, 16, 32 or 64 bits are legal, and only those are checked.
- R2: The operation code of byte k is `in_ops[2k+1:2k]`. A lane uses the code of its lowest byte. The codes are: 0 = low half; 1 = high half, A signed and B signed; 2 = high half, A signed and B unsigned; 3 = high half, A unsigned and B unsigned.
- R3: For a lane with code 0, the lane's field of `out_res` holds the low W bits of the product, where W is the lane width. With code 0 the result does not depend on signedness.
- R4: For a lane with a high-half code, the lane's field of `out_res` holds product bits [2W-1:W], computed with the signedness that the code gives.
- R5: Each lane's product, truncated to 2W bits, sits in `out_full` starting at twice the lane's bit offset. A lane with code 0 forms this product from signed operands.
- R6: When `out_ready` stays high, an operand pair accepted on one rising edge raises `out_valid` after the next rising edge. Result registers sit at two stages.
- R7: While `out_ready` is low, `in_ready` is low and `out_valid`, `out_res` and `out_full` hold their values.
- R8: Results leave in the order their operands entered. A transfer takes place only on an edge where valid and ready are both high.
- R9: While `rst` is high, `out_valid` is driven low and both result buses are cleared to zero.
- R10: With a=0x0123456789ABCDEF, b=0xFEDCBA9876543210, `in_bounds`=7'b0001011 and `in_ops`=16'h020D, the results are `out_res`=0x0121FA00FE1C28FE and `out_full`=0x0121FA0023E20B28C94DFE1C280AFEF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_bounds | input | 7 | Lane boundary flags, bit i marks bit 8*(i+1) |
| in_ops | input | 16 | Two-bit operation code per byte |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 64 | Packed lane results |
| out_full | output | 128 | Packed full lane products |

## Verification
The hardest situation to reach is a full pipeline held by a stall. It needs two items in flight, with the output frozen and the input refused. Only then can the bench see that the stage registers keep their contents and do not drop or reorder a result. The bench gets there directly: it feeds two pairs back to back and then pulls `out_ready` low for several cycles. After that, a long random stream runs with random output back-pressure and input gaps. This stream uses aligned layouts built by random recursive splitting, so that every lane width and every operation code appears at every legal offset.

// File: rtl/smul_pkg.sv
package smul_pkg;

    localparam int unsigned DW    = 64;           // operand width
    localparam int unsigned NB    = DW / 8;       // byte positions
    localparam int unsigned NFLG  = NB - 1;       // boundary flags
    localparam int unsigned OPW   = 2;            // code width per byte
    localparam int unsigned LVLS  = $clog2(NB) + 1; // lane size levels
    localparam int unsigned NCAND = 2 * NB - 1;   // aligned lane candidates

    typedef enum logic [OPW-1:0] {
        OP_LO    = 2'd0,
        OP_HI_SS = 2'd1,
        OP_HI_SU = 2'd2,
        OP_HI_UU = 2'd3
    } op_e;

    typedef struct packed {
        logic [DW-1:0]     a;
        logic [DW-1:0]     b;
        logic [NCAND-1:0]  pick;
        logic [NB*OPW-1:0] ops;
    } stage1_t;

    typedef struct packed {
        logic [DW-1:0]   res;
        logic [2*DW-1:0] full;
    } stage2_t;

    // first candidate index of a size level
    function automatic int cand_base(input int lvl);
        return 2 * NB - ((2 * NB) >> lvl);
    endfunction

    function automatic logic op_a_signed(input op_e o);
        return o != OP_HI_UU;
    endfunction

    function automatic logic op_b_signed(input op_e o);
        return (o == OP_LO) || (o == OP_HI_SS);
    endfunction

    function automatic logic op_high(input op_e o);
        return o != OP_LO;
    endfunction

endpackage

// File: rtl/smul_layout_dec.sv
module smul_layout_dec
    import smul_pkg::*;
(
    input  logic [NFLG-1:0]  flags,
    output logic [NCAND-1:0] pick
);

    logic [NB:0] bnd;
    assign bnd = {1'b1, flags, 1'b1};

    for (genvar lvl = 0; lvl < LVLS; lvl++) begin : g_lvl
        localparam int N = 1 << lvl;
        for (genvar i = 0; i < (NB >> lvl); i++) begin : g_lane
            localparam int S = i * N;
            localparam int C = cand_base(lvl) + i;
            localparam logic [NB:0] INNER =
                (NB + 1)'((1 << (S + N)) - (1 << (S + 1)));
            assign pick[C] = bnd[S] & bnd[S+N] & ~|(bnd & INNER);
        end
    end

endmodule

// File: rtl/smul_lane.sv
module smul_lane
    import smul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  op_e            op,
    output logic [W-1:0]   half,
    output logic [2*W-1:0] full
);

    logic signed [W:0]     ax;
    logic signed [W:0]     bx;
    logic signed [2*W+1:0] prod;

    assign ax   = $signed({op_a_signed(op) & a[W-1], a});
    assign bx   = $signed({op_b_signed(op) & b[W-1], b});
    assign prod = ax * bx;
    assign full = prod[2*W-1:0];
    assign half = op_high(op) ? full[2*W-1:W] : full[W-1:0];

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
    import smul_pkg::*;
(
    input  stage1_t s1,
    output stage2_t s2
);

    logic [DW-1:0]   cres  [NCAND];
    logic [2*DW-1:0] cfull [NCAND];

    for (genvar lvl = 0; lvl < LVLS; lvl++) begin : g_lvl
        localparam int N = 1 << lvl;
        localparam int W = 8 * N;
        for (genvar i = 0; i < (NB >> lvl); i++) begin : g_lane
            localparam int S   = i * N;
            localparam int OFF = 8 * S;
            localparam int C   = cand_base(lvl) + i;
            logic [W-1:0]   half;
            logic [2*W-1:0] full;

            smul_lane #(.W(W)) i_lane (
                .a    (s1.a[OFF +: W]),
                .b    (s1.b[OFF +: W]),
                .op   (op_e'(s1.ops[OPW*S +: OPW])),
                .half (half),
                .full (full)
            );

            assign cres[C]  = s1.pick[C] ? (DW'(half) << OFF) : '0;
            assign cfull[C] = s1.pick[C] ? ((2*DW)'(full) << (2*OFF)) : '0;
        end
    end

    always_comb begin
        s2 = '0;
        for (int c = 0; c < NCAND; c++) begin
            s2.res  = s2.res | cres[c];
            s2.full = s2.full | cfull[c];
        end
    end

endmodule

// File: rtl/simd_mul_part.sv
module simd_mul_part
    import smul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_a,
    input  logic [DW-1:0]     in_b,
    input  logic [NFLG-1:0]   in_bounds,
    input  logic [NB*OPW-1:0] in_ops,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_res,
    output logic [2*DW-1:0]   out_full
);

    logic             adv;
    logic [NCAND-1:0] pick_d;
    logic             v1_q;
    logic             v2_q;
    stage1_t          s1_q;
    stage2_t          s2_d;
    stage2_t          s2_q;

    assign adv      = out_ready;
    assign in_ready = adv;

    smul_layout_dec i_dec (
        .flags (in_bounds),
        .pick  (pick_d)
    );

    smul_datapath i_dp (
        .s1 (s1_q),
        .s2 (s2_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            s1_q <= '0;
            s2_q <= '0;
        end else if (adv) begin
            v1_q <= in_valid;
            v2_q <= v1_q;
            if (in_valid) begin
                s1_q.a    <= in_a;
                s1_q.b    <= in_b;
                s1_q.pick <= pick_d;
                s1_q.ops  <= in_ops;
            end
            if (v1_q) begin
                s2_q <= s2_d;
            end
        end
    end

    assign out_valid = v2_q;
    assign out_res   = s2_q.res;
    assign out_full  = s2_q.full;

endmodule

// File: rtl/smul_chk.sv
module smul_chk
    import smul_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [NFLG-1:0]   in_bounds,
    input logic [NB*OPW-1:0] in_ops,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DW-1:0]     out_res,
    input logic [2*DW-1:0]   out_full
);

    function automatic logic low_bytes_match(input logic [DW-1:0] r,
                                             input logic [2*DW-1:0] f);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < NB; k++) begin
            if (r[8*k +: 8] != f[16*k +: 8]) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid && out_res == '0 && out_full == '0); // R9

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !out_ready |=> $stable(out_valid) && $stable(out_res) && $stable(out_full)); // R7

    AST_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst, 1) && !$past(rst, 2) && $past(in_valid && in_ready, 2)
        && $past(out_ready, 1) |-> out_valid); // R6

    AST_LOW_IN_FULL: assert property (@(posedge clk) disable iff (rst)
        !$past(rst, 1) && !$past(rst, 2) && $past(out_ready, 1)
        && $past(in_valid && in_ready && in_bounds == '1 && in_ops == '0, 2)
        |-> low_bytes_match(out_res, out_full)); // R3

    AST_HIGH_IN_FULL: assert property (@(posedge clk) disable iff (rst)
        !$past(rst, 1) && !$past(rst, 2) && $past(out_ready, 1)
        && $past(in_valid && in_ready && in_bounds == '0 && in_ops[1:0] != 2'd0, 2)
        |-> out_res == out_full[2*DW-1:DW]); // R4

endmodule

bind simd_mul_part smul_chk i_chk (.*);

// File: tb/test_simd_mul_part.sv
module test_simd_mul_part;
    timeunit 1ns;
    timeprecision 1ps;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [63:0]   in_a = '0;
    logic [63:0]   in_b = '0;
    logic [6:0]    in_bounds = '0;
    logic [15:0]   in_ops = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [63:0]   out_res;
    logic [127:0]  out_full;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit rnd_ready = 1'b0;

    logic [63:0]  q_res  [$];
    logic [127:0] q_full [$];

    always #2.5 clk = ~clk;

    simd_mul_part i_simd_mul_part (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_bounds (in_bounds),
        .in_ops    (in_ops),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (out_res),
        .out_full  (out_full)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mask(input int n);
        logic [127:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    // reference model built from R1..R5
    task automatic ref_calc(input logic [63:0] a, input logic [63:0] b,
                            input logic [6:0] fl, input logic [15:0] ops,
                            output logic [63:0] res, output logic [127:0] full);
        int s;
        int n;
        int w;
        logic [1:0]   op;
        logic [127:0] ax, bx, m, pr, hv;
        res = '0;
        full = '0;
        s = 0;
        while (s < 8) begin
            n = 1;
            while (s + n < 8 && !fl[s+n-1]) n++;
            w = 8 * n;
            op = ops[2*s +: 2];
            m = mask(w);
            ax = (128'(a) >> (8*s)) & m;
            bx = (128'(b) >> (8*s)) & m;
            if (op != 2'd3 && ax[w-1]) ax = ax | ~m;
            if (op <= 2'd1 && bx[w-1]) bx = bx | ~m;
            pr = (ax * bx) & mask(2*w);
            full = full | (pr << (16*s));
            hv = (op != 2'd0) ? ((pr >> w) & m) : (pr & m);
            res = res | 64'(hv << (8*s));
            s = s + n;
        end
    endtask

    // one item: drive after a rising edge, accepted when in_ready seen
    task automatic send_item(input logic [63:0] a, input logic [63:0] b,
                             input logic [6:0] fl, input logic [15:0] ops);
        logic [63:0]  er;
        logic [127:0] ef;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        in_bounds = fl;
        in_ops = ops;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        ref_calc(a, b, fl, ops, er, ef);
        q_res.push_back(er);
        q_full.push_back(ef);
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [6:0] rand_layout();
        logic [6:0] f;
        f = '0;
        if ($urandom_range(0, 2) != 0) begin
            f[3] = 1'b1;
            if ($urandom_range(0, 1) != 0) begin
                f[1] = 1'b1;
                f[0] = 1'($urandom_range(0, 1));
                f[2] = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 1) != 0) begin
                f[5] = 1'b1;
                f[4] = 1'($urandom_range(0, 1));
                f[6] = 1'($urandom_range(0, 1));
            end
        end
        return f;
    endfunction

    function automatic logic [63:0] rand_word();
        logic [63:0] w;
        w = {$urandom(), $urandom()};
        case ($urandom_range(0, 5))
            0: w = 64'h8080_8080_8080_8080;
            1: w = '1;
            default: ;
        endcase
        return w;
    endfunction

    // scoreboard monitor: R3 R4 R5 contents, R8 order
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (q_res.size() == 0) begin
                chk(1'b0, "R8 result with nothing pending", 128'(out_res), '0);
            end else begin
                logic [63:0]  er;
                logic [127:0] ef;
                er = q_res.pop_front();
                ef = q_full.pop_front();
                chk(out_res == er, "R1 R2 R3 R4 R8 packed result", 128'(out_res), 128'(er));
                chk(out_full == ef, "R5 R8 full products", out_full, ef);
            end
        end
    end

    always @(posedge clk) begin
        if (rnd_ready) begin
            #1;
            out_ready = ($urandom_range(0, 3) != 0);
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", '0, '0);
            finish_run();
        end
    end

    initial begin
        logic [63:0]  hold_res;
        logic [127:0] hold_full;
        int wait_cnt;

        // R9 reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid in reset", 128'(out_valid), 0);
        chk(out_res == '0, "R9 out_res in reset", 128'(out_res), 0);
        chk(out_full == '0, "R9 out_full in reset", out_full, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        out_ready = 1'b1;

        // R10 known vector and R6 latency
        send_item(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 7'b0001011, 16'h020D);
        idle();
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 not valid after one edge", 128'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R6 valid after second edge", 128'(out_valid), 1);
        chk(out_res == 64'h0121FA00FE1C28FE, "R10 packed result", 128'(out_res),
            128'h0121FA00FE1C28FE);
        chk(out_full == 128'h0121FA0023E20B28C94DFE1C280AFEF0, "R10 full products",
            out_full, 128'h0121FA0023E20B28C94DFE1C280AFEF0);

        // directed layouts and codes: R1 R2 R3 R4 R5
        send_item(64'h80FF_7F01_8000_FFFF, 64'hFF80_7F02_0180_FFFF, 7'h7F, 16'h0000);
        send_item(64'h80FF_7F01_8000_FFFF, 64'hFF80_7F02_0180_FFFF, 7'h7F, 16'hE4E4);
        send_item(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 7'h00, 16'h0001);
        send_item(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'h00, 16'h0002);
        send_item(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'h00, 16'h0003);
        send_item(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 7'h00, 16'hFFFC);
        send_item(64'h8001_7FFF_FFFF_0002, 64'hFFFF_8000_7FFF_8001, 7'h2A, 16'h3210);
        send_item(64'h8000_0001_7FFF_FFFF, 64'h8000_0001_FFFF_FFFF, 7'h08, 16'h0301);
        idle();

        // R7 stall with two items in flight
        send_item(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 7'h2A, 16'h1111);
        send_item(64'hDEAD_BEEF_0BAD_F00D, 64'hFACE_CAFE_1234_5678, 7'h08, 16'h0302);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R7 in_ready low while stalled", 128'(in_ready), 0);
        chk(out_valid == 1'b1, "R7 result present at stall", 128'(out_valid), 1);
        hold_res = out_res;
        hold_full = out_full;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b1, "R7 valid held", 128'(out_valid), 1);
        chk(out_res == hold_res, "R7 out_res held", 128'(out_res), 128'(hold_res));
        chk(out_full == hold_full, "R7 out_full held", out_full, hold_full);
        @(posedge clk);
        #1;
        out_ready = 1'b1;

        // random stream with back-pressure: R1..R5, R8
        rnd_ready = 1'b1;
        for (int n = 0; n < 400; n++) begin
            send_item(rand_word(), rand_word(), rand_layout(),
                      16'({$urandom(), $urandom()}));
            if ($urandom_range(0, 4) == 0) idle();
        end
        idle();
        rnd_ready = 1'b0;
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        wait_cnt = 0;
        while (q_res.size() != 0 && wait_cnt < 100) begin
            @(negedge clk);
            wait_cnt++;
        end
        repeat (3) @(negedge clk);
        chk(q_res.size() == 0, "R8 every item delivered", 128'(q_res.size()), 0);
        done = 1'b1;
        finish_run();
    end

endmodule